// File: doc/BRIEF.md
# Configuration Preload and Lockout Gate

This block controls the power-up configuration sequence of a two-sided bridge. When reset is released and a serial EEPROM is fitted, it clocks a read command out to the EEPROM. It checks the signature of the first word returned. It then streams the remaining words into a local register file through a simple write port. While the load runs, every configuration request on either bus side is answered with a retry, so no agent can see a half-built register set.

When the load ends, access is asymmetric. The secondary (local) side always completes. The primary (host) side is held off by a lockout flag whose reset value comes from a strap input. Only one exempt offset, D8h, completes on the primary side while the flag is set. Local firmware finishes its setup and then clears the flag with a secondary write, which opens the primary side. If the EEPROM is missing, the load is skipped. If the signature is wrong, the load is abandoned and nothing is written.

Top module: `cfg_boot_gate`

## Requirements
- R1: When `ee_present` is high at reset release, `ee_cs` rises within two cycles. `ee_sk` then runs with a period of 2*CLK_HALF clocks. `ee_di` first carries a start bit 1, then opcode bits 1,0, then ADDR_BITS zero address bits, MSB first. `ee_di` changes only on falling `ee_sk` edges.
- R2: When `ee_present` is low, no serial activity occurs (`ee_cs` stays low). Configuration requests sampled from the second clock after reset release onward are no longer retried for loading.
- R3: While the load is in progress, every request on both ports gets a retry. A secondary write to the lockout offset during the load has no effect on the flag.
- R4: The first 16-bit word read must have bits [15:14] equal to binary 10. For any other value, `ee_cs` drops right after that word, no register-file write occurs, and both ports become accessible.
- R5: With a valid signature, the next NUM_WORDS words are written in order. Each word is shifted in MSB first, sampled on falling `ee_sk`, and written with a one-cycle `rf_we` pulse at indices 0, 1, 2, and so on. `ee_cs` drops after the last word.
- R6: The lockout flag takes the value of `strap_lock` sampled while reset is asserted. A value of 1 means locked.
- R7: After the load, while the flag is 1, primary requests are retried, except requests to offset D8h, which complete.
- R8: After the load, secondary requests complete regardless of the flag.
- R9: A completed secondary write to offset CCh loads write-data bit 0 into the flag. Writing 0 releases the primary side and writing 1 locks it again. Primary writes to CCh do not change the flag.
- R10: Each request gets exactly one response, with `rsp_valid` asserted on the cycle after the request is sampled. `rsp_retry` = 1 means retry and 0 means complete. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Primary clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_lock | input | 1 | Lockout reset-value strap, sampled during reset |
| ee_present | input | 1 | High when a serial EEPROM is fitted |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| p_req_valid | input | 1 | Primary configuration request strobe |
| p_req_off | input | 8 | Primary request register offset |
| p_req_wr | input | 1 | Primary request is a write |
| p_req_wdata | input | 32 | Primary write data |
| p_rsp_valid | output | 1 | Primary response strobe |
| p_rsp_retry | output | 1 | Primary response: 1 retry, 0 complete |
| s_req_valid | input | 1 | Secondary configuration request strobe |
| s_req_off | input | 8 | Secondary request register offset |
| s_req_wr | input | 1 | Secondary request is a write |
| s_req_wdata | input | 32 | Secondary write data |
| s_rsp_valid | output | 1 | Secondary response strobe |
| s_rsp_retry | output | 1 | Secondary response: 1 retry, 0 complete |
| rf_we | output | 1 | Register-file write pulse |
| rf_idx | output | 6 | Register-file word index |
| rf_wdata | output | 16 | Register-file write data |

## Verification
The bench tries to clear the lockout while the load is still running. A design that acted on writes it had retried would then open the primary side early. It checks the D8h exemption and the primary-side write to the flag offset. A gate that decoded offsets on both sides, or let either port write the flag, would complete requests it should retry. It feeds three bad signature values and checks the word count and index order of a good load. An off-by-one in the word counter, or a commit made before the signature check, shows up as extra, missing or shifted register-file writes. It also measures the serial clock period and the command bits the EEPROM model captures, which catches a wrong divider phase or a misordered command.

// File: rtl/cfgboot_pkg.sv
// Shared types and constants for the configuration preload and lockout gate.
// Assumes a three-bit serial read command followed by a zero start address.
package cfgboot_pkg;
    typedef enum logic [1:0] {
        LD_START = 2'd0,
        LD_CMD   = 2'd1,
        LD_DATA  = 2'd2,
        LD_DONE  = 2'd3
    } ld_state_e;

    // start bit followed by the read opcode
    localparam logic [2:0] EE_READ_CMD = 3'b110;
    // required top two bits of the signature word
    localparam logic [1:0] HDR_SIG     = 2'b10;
    localparam int         WORD_W      = 16;
endpackage

// File: rtl/cfgboot_clkdiv.sv
// Serial clock phase generator: pulses tick once every CLK_HALF cycles while en is high.
// Assumes CLK_HALF >= 2; the count restarts whenever en drops.
module cfgboot_clkdiv #(
    parameter int CLK_HALF = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(CLK_HALF);

    logic [CW-1:0] cnt;

    // counts clock cycles within one half-period of the serial clock
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == CW'(CLK_HALF - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == CW'(CLK_HALF - 1));
endmodule

// File: rtl/cfgboot_loader.sv
// Serial preload sequencer: sends the read command, checks the signature word,
// and streams NUM_WORDS data words into the register-file write port.
// Assumes the EEPROM updates its data out on rising ee_sk; data is sampled on falling ee_sk.
module cfgboot_loader #(
    parameter int CLK_HALF  = 17,
    parameter int NUM_WORDS = 33,
    parameter int ADDR_BITS = 6,
    parameter int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ee_present,
    input  logic                           ee_do,
    output logic                           ee_cs,
    output logic                           ee_sk,
    output logic                           ee_di,
    output logic                           busy,
    output logic                           rf_we,
    output logic [IDX_W-1:0]               rf_idx,
    output logic [cfgboot_pkg::WORD_W-1:0] rf_wdata
);
    import cfgboot_pkg::*;

    localparam int CMD_BITS = 3 + ADDR_BITS;
    localparam int BC_MAX   = (CMD_BITS > WORD_W) ? CMD_BITS : WORD_W;
    localparam int BC_W     = $clog2(BC_MAX);
    localparam int CNT_W    = $clog2(NUM_WORDS + 1);
    localparam logic [CMD_BITS-1:0] CMD_WORD = {EE_READ_CMD, {ADDR_BITS{1'b0}}};

    ld_state_e            state;
    logic                 tick;
    logic [CMD_BITS-1:0]  cmd_sr;
    logic [BC_W-1:0]      bit_cnt;
    logic [CNT_W-1:0]     word_cnt;
    logic [WORD_W-2:0]    shreg;
    logic [WORD_W-1:0]    word_in;
    logic                 fall;

    cfgboot_clkdiv #(.CLK_HALF(CLK_HALF)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ee_cs),
        .tick (tick)
    );

    // a falling serial-clock edge is the bit boundary for both directions
    assign fall    = tick && ee_sk;
    assign word_in = {shreg, ee_do};
    assign busy    = (state != LD_DONE);

    // main sequencer: command phase, data phase, completion or abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LD_START;
            ee_cs    <= 1'b0;
            ee_sk    <= 1'b0;
            ee_di    <= 1'b0;
            cmd_sr   <= CMD_WORD;
            bit_cnt  <= '0;
            word_cnt <= '0;
            shreg    <= '0;
            rf_we    <= 1'b0;
            rf_idx   <= '0;
            rf_wdata <= '0;
        end else begin
            rf_we <= 1'b0;
            if (tick && !ee_sk) begin
                ee_sk <= 1'b1;
            end
            case (state)
                LD_START: begin
                    if (ee_present) begin
                        state   <= LD_CMD;
                        ee_cs   <= 1'b1;
                        ee_di   <= CMD_WORD[CMD_BITS-1];
                        cmd_sr  <= CMD_WORD << 1;
                        bit_cnt <= '0;
                    end else begin
                        state <= LD_DONE;
                    end
                end
                LD_CMD: begin
                    if (fall) begin
                        ee_sk <= 1'b0;
                        if (bit_cnt == BC_W'(CMD_BITS - 1)) begin
                            state   <= LD_DATA;
                            bit_cnt <= '0;
                            ee_di   <= 1'b0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            ee_di   <= cmd_sr[CMD_BITS-1];
                            cmd_sr  <= cmd_sr << 1;
                        end
                    end
                end
                LD_DATA: begin
                    if (fall) begin
                        ee_sk <= 1'b0;
                        shreg <= word_in[WORD_W-2:0];
                        if (bit_cnt == BC_W'(WORD_W - 1)) begin
                            bit_cnt <= '0;
                            if (word_cnt == '0) begin
                                if (word_in[WORD_W-1 -: 2] != HDR_SIG) begin
                                    state <= LD_DONE;
                                    ee_cs <= 1'b0;
                                end else begin
                                    word_cnt <= word_cnt + 1'b1;
                                end
                            end else begin
                                rf_we    <= 1'b1;
                                rf_idx   <= IDX_W'(word_cnt - 1'b1);
                                rf_wdata <= word_in;
                                if (word_cnt == CNT_W'(NUM_WORDS)) begin
                                    state <= LD_DONE;
                                    ee_cs <= 1'b0;
                                end else begin
                                    word_cnt <= word_cnt + 1'b1;
                                end
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    ee_cs <= 1'b0;
                    ee_sk <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/cfgboot_lockreg.sv
// Primary-side lockout flag: follows the strap during reset, then changes only
// on a completed secondary write to LOCK_OFF.
// Assumes the caller presents only secondary-port writes on wr_en.
module cfgboot_lockreg #(
    parameter int              OFF_W    = 8,
    parameter logic [OFF_W-1:0] LOCK_OFF = 8'hCC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap,
    input  logic             busy,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic             wr_bit,
    output logic             lock
);
    // strap capture in reset, firmware update once the load is finished
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock <= strap;
        end else if (wr_en && !busy && (wr_off == LOCK_OFF)) begin
            lock <= wr_bit;
        end
    end
endmodule

// File: rtl/cfgboot_port_gate.sv
// Per-port response generator: one registered response per request, retry or complete.
// IS_PRIMARY selects whether the lockout flag and its exempt offset apply.
module cfgboot_port_gate #(
    parameter int               OFF_W      = 8,
    parameter bit               IS_PRIMARY = 1'b0,
    parameter logic [OFF_W-1:0] EXEMPT_OFF = 8'hD8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             lock,
    input  logic             req_valid,
    input  logic [OFF_W-1:0] req_off,
    output logic             rsp_valid,
    output logic             rsp_retry
);
    logic held_off;

    // lockout only affects the primary side, and never the exempt offset
    assign held_off = IS_PRIMARY && lock && (req_off != EXEMPT_OFF);

    // registers the response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_retry <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_retry <= req_valid && (busy || held_off);
        end
    end
endmodule

// File: rtl/cfg_boot_gate.sv
// Top of the configuration preload and lockout gate. Ties the serial loader,
// the lockout flag and the two request gates together.
// Assumes simple single-beat requests; register contents live outside this block.
module cfg_boot_gate #(
    parameter int               CLK_HALF   = 17,
    parameter int               NUM_WORDS  = 33,
    parameter int               ADDR_BITS  = 6,
    parameter int               OFF_W      = 8,
    parameter int               DATA_W     = 32,
    parameter logic [OFF_W-1:0] EXEMPT_OFF = 8'hD8,
    parameter logic [OFF_W-1:0] LOCK_OFF   = 8'hCC,
    parameter int               LOCK_BIT   = 0,
    parameter int               IDX_W      = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_lock,
    input  logic              ee_present,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do,
    input  logic              p_req_valid,
    input  logic [OFF_W-1:0]  p_req_off,
    input  logic              p_req_wr,
    input  logic [DATA_W-1:0] p_req_wdata,
    output logic              p_rsp_valid,
    output logic              p_rsp_retry,
    input  logic              s_req_valid,
    input  logic [OFF_W-1:0]  s_req_off,
    input  logic              s_req_wr,
    input  logic [DATA_W-1:0] s_req_wdata,
    output logic              s_rsp_valid,
    output logic              s_rsp_retry,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_idx,
    output logic [15:0]       rf_wdata
);
    logic load_busy;
    logic lock_q;
    logic unused_wr_inputs;

    // primary writes never reach the flag; only one secondary data bit is decoded
    assign unused_wr_inputs = ^{p_req_wr, p_req_wdata, s_req_wdata};

    cfgboot_loader #(
        .CLK_HALF (CLK_HALF),
        .NUM_WORDS(NUM_WORDS),
        .ADDR_BITS(ADDR_BITS),
        .IDX_W    (IDX_W)
    ) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .ee_present(ee_present),
        .ee_do     (ee_do),
        .ee_cs     (ee_cs),
        .ee_sk     (ee_sk),
        .ee_di     (ee_di),
        .busy      (load_busy),
        .rf_we     (rf_we),
        .rf_idx    (rf_idx),
        .rf_wdata  (rf_wdata)
    );

    cfgboot_lockreg #(
        .OFF_W   (OFF_W),
        .LOCK_OFF(LOCK_OFF)
    ) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .strap (strap_lock),
        .busy  (load_busy),
        .wr_en (s_req_valid && s_req_wr),
        .wr_off(s_req_off),
        .wr_bit(s_req_wdata[LOCK_BIT]),
        .lock  (lock_q)
    );

    cfgboot_port_gate #(
        .OFF_W     (OFF_W),
        .IS_PRIMARY(1'b1),
        .EXEMPT_OFF(EXEMPT_OFF)
    ) u_pgate (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (load_busy),
        .lock     (lock_q),
        .req_valid(p_req_valid),
        .req_off  (p_req_off),
        .rsp_valid(p_rsp_valid),
        .rsp_retry(p_rsp_retry)
    );

    cfgboot_port_gate #(
        .OFF_W     (OFF_W),
        .IS_PRIMARY(1'b0),
        .EXEMPT_OFF(EXEMPT_OFF)
    ) u_sgate (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (load_busy),
        .lock     (lock_q),
        .req_valid(s_req_valid),
        .req_off  (s_req_off),
        .rsp_valid(s_rsp_valid),
        .rsp_retry(s_rsp_retry)
    );
endmodule

// File: rtl/cfgboot_chk.sv
// Protocol checker for cfg_boot_gate, attached through bind below.
// Relates request ports, responses, the load phase and the lockout flag over time.
module cfgboot_chk #(
    parameter int               OFF_W      = 8,
    parameter logic [OFF_W-1:0] EXEMPT_OFF = 8'hD8,
    parameter logic [OFF_W-1:0] LOCK_OFF   = 8'hCC
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             lock,
    input logic             ee_cs,
    input logic             ee_sk,
    input logic             rf_we,
    input logic             p_req_valid,
    input logic [OFF_W-1:0] p_req_off,
    input logic             p_rsp_valid,
    input logic             p_rsp_retry,
    input logic             s_req_valid,
    input logic [OFF_W-1:0] s_req_off,
    input logic             s_req_wr,
    input logic             s_rsp_valid,
    input logic             s_rsp_retry
);
    // R3: both sides retried for the whole load
    a_r3_pri_retry_loading: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && p_req_valid) |=> (p_rsp_valid && p_rsp_retry));
    a_r3_sec_retry_loading: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && s_req_valid) |=> (s_rsp_valid && s_rsp_retry));

    // R7: lockout holds off the primary side except the exempt offset
    a_r7_lockout_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && lock && p_req_valid && p_req_off != EXEMPT_OFF) |=> p_rsp_retry);
    a_r7_exempt_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && p_req_valid && p_req_off == EXEMPT_OFF) |=> (p_rsp_valid && !p_rsp_retry));

    // R8: secondary completes once loading is over
    a_r8_sec_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && s_req_valid) |=> (s_rsp_valid && !s_rsp_retry));

    // R9: flag changes only through a secondary write to its offset
    a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_req_valid && s_req_wr && s_req_off == LOCK_OFF) |=> $stable(lock));

    // R10: one response per request, none otherwise
    a_r10_pri_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !p_req_valid |=> !p_rsp_valid);
    a_r10_sec_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !s_req_valid |=> !s_rsp_valid);

    // R1: serial clock is idle whenever the EEPROM is deselected
    a_r1_sk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);

    // R5: register-file writes are single-cycle pulses
    a_r5_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);
endmodule

bind cfg_boot_gate cfgboot_chk #(
    .OFF_W     (OFF_W),
    .EXEMPT_OFF(EXEMPT_OFF),
    .LOCK_OFF  (LOCK_OFF)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (load_busy),
    .lock       (lock_q),
    .ee_cs      (ee_cs),
    .ee_sk      (ee_sk),
    .rf_we      (rf_we),
    .p_req_valid(p_req_valid),
    .p_req_off  (p_req_off),
    .p_rsp_valid(p_rsp_valid),
    .p_rsp_retry(p_rsp_retry),
    .s_req_valid(s_req_valid),
    .s_req_off  (s_req_off),
    .s_req_wr   (s_req_wr),
    .s_rsp_valid(s_rsp_valid),
    .s_rsp_retry(s_rsp_retry)
);

// File: tb/cfg_boot_gate_tb.sv
// Directed bench for cfg_boot_gate with a behavioural serial EEPROM.
module cfg_boot_gate_tb;
    localparam int HALF = 17;
    localparam int NW   = 33;
    localparam int AB   = 6;
    localparam int CMDB = 3 + AB;
    localparam int IW   = $clog2(NW);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          strap_lock = 1'b0;
    logic          ee_present = 1'b0;
    logic          ee_cs, ee_sk, ee_di;
    logic          ee_do = 1'b0;
    logic          p_req_valid = 1'b0, p_req_wr = 1'b0;
    logic [7:0]    p_req_off = '0;
    logic [31:0]   p_req_wdata = '0;
    logic          p_rsp_valid, p_rsp_retry;
    logic          s_req_valid = 1'b0, s_req_wr = 1'b0;
    logic [7:0]    s_req_off = '0;
    logic [31:0]   s_req_wdata = '0;
    logic          s_rsp_valid, s_rsp_retry;
    logic          rf_we;
    logic [IW-1:0] rf_idx;
    logic [15:0]   rf_wdata;

    cfg_boot_gate u_dut (
        .clk(clk), .rst_n(rst_n), .strap_lock(strap_lock), .ee_present(ee_present),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
        .p_req_valid(p_req_valid), .p_req_off(p_req_off), .p_req_wr(p_req_wr),
        .p_req_wdata(p_req_wdata), .p_rsp_valid(p_rsp_valid), .p_rsp_retry(p_rsp_retry),
        .s_req_valid(s_req_valid), .s_req_off(s_req_off), .s_req_wr(s_req_wr),
        .s_req_wdata(s_req_wdata), .s_rsp_valid(s_rsp_valid), .s_rsp_retry(s_rsp_retry),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // behavioural EEPROM: captures command bits, then shifts words out on rising sk
    logic [15:0]     mem [0:NW];
    logic [CMDB-1:0] cmd_cap = '0;
    int              ee_cnt = 0;
    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            ee_cnt <= 0;
            ee_do  <= 1'b0;
        end else if (ee_cnt < CMDB) begin
            cmd_cap <= {cmd_cap[CMDB-2:0], ee_di};
            ee_cnt  <= ee_cnt + 1;
        end else begin
            ee_do  <= ((ee_cnt - CMDB) / 16 <= NW) ?
                      mem[(ee_cnt - CMDB) / 16][15 - ((ee_cnt - CMDB) % 16)] : 1'b0;
            ee_cnt <= ee_cnt + 1;
        end
    end

    // register-file write capture and serial-activity monitor
    logic [15:0] cap [0:NW-1];
    int rf_n = 0;
    int idx_err = 0;
    bit cs_seen = 1'b0;
    bit di_bad = 1'b0;
    logic sk_d = 1'b0;
    logic di_d = 1'b0;
    always @(negedge clk) begin
        if (rf_we) begin
            if (rf_idx != IW'(rf_n)) idx_err <= idx_err + 1;
            if (rf_n < NW) cap[rf_n] <= rf_wdata;
            rf_n <= rf_n + 1;
        end
        if (ee_cs) cs_seen <= 1'b1;
        if (ee_cs && sk_d && ee_sk && (ee_di != di_d)) di_bad <= 1'b1;
        sk_d <= ee_sk;
        di_d <= ee_di;
    end

    function automatic logic [15:0] exp_word(input int i);
        return 16'h1234 ^ 16'(i * 16'h0357);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one request on a port, returns retry flag; checks response timing (R10)
    task automatic do_req(input bit pri, input logic [7:0] off, input bit wr,
                          input logic [31:0] data, output bit retry);
        bit vld;
        if (pri) begin
            p_req_valid = 1'b1; p_req_off = off; p_req_wr = wr; p_req_wdata = data;
        end else begin
            s_req_valid = 1'b1; s_req_off = off; s_req_wr = wr; s_req_wdata = data;
        end
        @(negedge clk);
        vld   = pri ? p_rsp_valid : s_rsp_valid;
        retry = pri ? p_rsp_retry : s_rsp_retry;
        p_req_valid = 1'b0; p_req_wr = 1'b0;
        s_req_valid = 1'b0; s_req_wr = 1'b0;
        chk(vld, "R10", "response strobe after request", vld, 1);
        @(negedge clk);
        vld = pri ? p_rsp_valid : s_rsp_valid;
        chk(!vld, "R10", "no second response", vld, 0);
    endtask

    task automatic apply_reset(input bit strap, input bit present);
        @(negedge clk);
        rst_n = 1'b0; strap_lock = strap; ee_present = present;
        repeat (4) @(negedge clk);
        chk(!ee_cs && !ee_sk && !p_rsp_valid && !s_rsp_valid && !rf_we, "R10",
            "idle outputs in reset", {ee_cs, ee_sk, p_rsp_valid, s_rsp_valid, rf_we}, 0);
        rf_n = 0; idx_err = 0; cs_seen = 1'b0; di_bad = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic wait_cs_low(input int limit, output int took);
        took = 0;
        while (ee_cs && took < limit) begin
            @(negedge clk);
            took++;
        end
    endtask

    task automatic t_absent();
        bit r;
        apply_reset(1'b1, 1'b0);
        do_req(1'b0, 8'h10, 1'b0, 0, r);
        chk(r, "R2", "first-cycle request still retried", r, 1);
        do_req(1'b0, 8'h10, 1'b0, 0, r);
        chk(!r, "R2", "secondary completes without EEPROM", r, 0);
        do_req(1'b1, 8'h10, 1'b0, 0, r);
        chk(r, "R6", "strap high locks primary", r, 1);
        do_req(1'b1, 8'hD8, 1'b0, 0, r);
        chk(!r, "R7", "exempt offset completes", r, 0);
        repeat (100) @(negedge clk);
        chk(!cs_seen, "R2", "no chip select without EEPROM", cs_seen, 0);
    endtask

    task automatic t_good_load(input bit strap);
        bit r;
        int t0, took, bad;
        mem[0] = 16'hA5C3;
        for (int i = 1; i <= NW; i++) mem[i] = exp_word(i - 1);
        apply_reset(strap, 1'b1);
        repeat (2) @(negedge clk);
        chk(ee_cs, "R1", "chip select after reset", ee_cs, 1);
        @(posedge ee_sk); t0 = cyc;
        @(posedge ee_sk);
        chk(cyc - t0 == 2 * HALF, "R1", "serial clock period", cyc - t0, 2 * HALF);
        @(negedge clk);
        do_req(1'b1, 8'h10, 1'b0, 0, r);
        chk(r, "R3", "primary retried while loading", r, 1);
        do_req(1'b0, 8'h10, 1'b0, 0, r);
        chk(r, "R3", "secondary retried while loading", r, 1);
        do_req(1'b0, 8'hCC, 1'b1, 32'h0, r);
        chk(r, "R3", "flag write retried while loading", r, 1);
        wait_cs_low(25000, took);
        chk(!ee_cs, "R5", "load finishes", ee_cs, 0);
        chk(cmd_cap == {3'b110, {AB{1'b0}}}, "R1", "command bits", cmd_cap,
            {3'b110, {AB{1'b0}}});
        chk(!di_bad, "R1", "data in stable while sk high", di_bad, 0);
        @(negedge clk);
        chk(rf_n == NW, "R5", "word count", rf_n, NW);
        chk(idx_err == 0, "R5", "index order errors", idx_err, 0);
        bad = 0;
        for (int i = 0; i < NW; i++) if (cap[i] !== exp_word(i)) bad++;
        chk(bad == 0, "R5", "word data mismatches", bad, 0);
        do_req(1'b0, 8'h10, 1'b0, 0, r);
        chk(!r, "R8", "secondary completes after load", r, 0);
        do_req(1'b1, 8'h10, 1'b0, 0, r);
        if (strap) begin
            chk(r, "R3", "flag write during load ignored", r, 1);
            do_req(1'b1, 8'hD8, 1'b1, 32'h1, r);
            chk(!r, "R7", "exempt offset completes when locked", r, 0);
            do_req(1'b1, 8'hCC, 1'b1, 32'h0, r);
            do_req(1'b1, 8'h10, 1'b0, 0, r);
            chk(r, "R9", "primary write to flag ignored", r, 1);
            do_req(1'b0, 8'hCC, 1'b1, 32'h0, r);
            do_req(1'b1, 8'h10, 1'b0, 0, r);
            chk(!r, "R9", "secondary clear releases primary", r, 0);
            do_req(1'b0, 8'hCC, 1'b1, 32'h1, r);
            do_req(1'b1, 8'h20, 1'b0, 0, r);
            chk(r, "R9", "secondary set locks again", r, 1);
        end else begin
            chk(!r, "R6", "strap low leaves primary open", r, 0);
        end
    endtask

    task automatic t_bad_header(input logic [15:0] hdr);
        bit r;
        int took;
        mem[0] = hdr;
        for (int i = 1; i <= NW; i++) mem[i] = exp_word(i - 1);
        apply_reset(1'b0, 1'b1);
        repeat (2) @(negedge clk);
        wait_cs_low(3000, took);
        chk(took <= (CMDB + 16) * 2 * HALF + 4 * HALF, "R4", "abort after signature",
            took, (CMDB + 16) * 2 * HALF);
        repeat (40) @(negedge clk);
        chk(rf_n == 0, "R4", "no writes on abort", rf_n, 0);
        do_req(1'b0, 8'h10, 1'b0, 0, r);
        chk(!r, "R4", "secondary open after abort", r, 0);
        do_req(1'b1, 8'h10, 1'b0, 0, r);
        chk(!r, "R4", "primary open after abort", r, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 190000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        t_absent();
        t_good_load(1'b1);
        t_good_load(1'b0);
        t_bad_header(16'h6A5C);
        t_bad_header(16'hC000);
        t_bad_header(16'h0000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule